// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM With Zero Write-to-Read Turnaround

This block models a synchronous static RAM whose read data flows from the array to the pins with no output register. Address, write enable and the three chip enables are registered on the rising clock edge. Write data and its byte mask follow their address by one enabled edge. The output drivers turn themselves off during every write data phase. Reads and writes can therefore be mixed freely on consecutive cycles, and the bus never needs an idle cycle to turn around.

A clock enable suspends the block. Any edge taken while it is deasserted leaves captured state, pending writes and the driven output exactly as they were. An asynchronous output enable gates the drivers without waiting for a clock. The data bus is split into `din`, `dout` and `dout_en` so that a wrapper can join them into a bidirectional pad. The word is built from byte lanes of `LANE_W` bits, `LANES` of them. The defaults, 4 lanes of 9 bits, give a 36-bit word. The array depth is kept small for simulation.

Top module: `ft_sync_ram`

## Requirements
- R1: Address, write enable and the chip enables are taken only on a rising edge with `cen_n` low. Changes between edges do not alter the location being read.
- R2: For a selected read (`we_n` high) taken on edge k, `dout` carries the stored word from edge k until the next enabled edge. `dout_en` is high when `oe_n` is low.
- R3: A write address is taken on edge k. Its data (`din`) and lane mask (`bw_n`) are taken on the next enabled edge. Only lanes whose `bw_n[i]` is 0 are changed, where lane i is bits [i*LANE_W+LANE_W-1 : i*LANE_W]. An all-ones mask leaves the word unchanged.
- R4: Reads and writes can alternate on every clock with no idle cycle, and every read returns correct data.
- R5: A read of the address written on the immediately preceding edge returns the word with the new lanes merged in.
- R6: During the cycle after a write address is taken, `dout_en` is low whatever the level of `oe_n`.
- R7: `oe_n` high forces `dout_en` low at once, without a clock edge.
- R8: An edge with `cen_n` high is ignored. `dout` and `dout_en` hold, and a pending write stays pending until the next enabled edge supplies its data.
- R9: The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect: `dout_en` is low in the following cycle and no write is started.
- R10: A deselect edge still completes a write whose address was taken on the previous enabled edge.
- R11: While and after `rst` is high, no operation is pending and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write request, active low |
| addr | input | AW | Word address |
| bw_n | input | LANES | Lane write mask, active low, taken in the data phase |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Flow-through read data |
| dout_en | output | 1 | Output driver enable |

## Verification
Some properties are checked on every cycle. The drivers must be off in the cycle after a write or deselect edge and while `oe_n` is high. A selected read must enable them when `oe_n` is low. A suspended edge must leave `dout` and `dout_en` unchanged. The data itself can only be shown by the bench's scenarios. These cover lane merging, a read that directly follows a write to the same word, a pending write held across suspended edges and completed on a deselect edge, deselect patterns that must not write, and long alternating read/write runs.

// File: rtl/ft_ram_pkg.sv
package ft_ram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic logic chip_selected(input logic a_n, input logic b, input logic c_n);
        return !a_n && b && !c_n;
    endfunction

    function automatic op_e decode_op(input logic sel, input logic we_n);
        if (!sel)
            return OP_IDLE;
        return we_n ? OP_READ : OP_WRITE;
    endfunction

endpackage

// File: rtl/ft_ram_capture.sv
module ft_ram_capture
    import ft_ram_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cen_n,
    input  logic          sel_a_n,
    input  logic          sel_b,
    input  logic          sel_c_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output op_e           op_q,
    output logic [AW-1:0] addr_q,
    output logic          commit
);

    logic sel;

    assign sel = chip_selected(sel_a_n, sel_b, sel_c_n);

    // A write captured on the previous enabled edge completes on this one,
    // whatever is captured now (deselect included).
    assign commit = !cen_n && (op_q == OP_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
        end else if (!cen_n) begin
            op_q   <= decode_op(sel, we_n);
            addr_q <= addr;
        end
    end

endmodule

// File: rtl/ft_ram_array.sv
module ft_ram_array #(
    parameter int AW     = 5,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [LANES-1:0]        wr_lane_n,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && !wr_lane_n[g])
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        // Flow-through: no output register on the read side.
        assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/ft_ram_drive.sv
module ft_ram_drive
    import ft_ram_pkg::*;
#(
    parameter int DW = 36
) (
    input  op_e           op_q,
    input  logic          oe_n,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    always_comb begin
        dout    = rd_data;
        dout_en = (op_q == OP_READ) && !oe_n;
    end

endmodule

// File: rtl/ft_sync_ram.sv
module ft_sync_ram
    import ft_ram_pkg::*;
#(
    parameter int AW     = 5,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cen_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             we_n,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] bw_n,
    input  logic             oe_n,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic             dout_en
);

    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic          commit;
    logic [DW-1:0] rd_data;

    ft_ram_capture #(.AW(AW)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .cen_n   (cen_n),
        .sel_a_n (sel_a_n),
        .sel_b   (sel_b),
        .sel_c_n (sel_c_n),
        .we_n    (we_n),
        .addr    (addr),
        .op_q    (op_q),
        .addr_q  (addr_q),
        .commit  (commit)
    );

    ft_ram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk       (clk),
        .wr_en     (commit),
        .wr_addr   (addr_q),
        .wr_data   (din),
        .wr_lane_n (bw_n),
        .rd_addr   (addr_q),
        .rd_data   (rd_data)
    );

    ft_ram_drive #(.DW(DW)) u_drv (
        .op_q    (op_q),
        .oe_n    (oe_n),
        .rd_data (rd_data),
        .dout    (dout),
        .dout_en (dout_en)
    );

endmodule

// File: rtl/ft_sync_ram_chk.sv
module ft_sync_ram_chk #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst,
    input logic          cen_n,
    input logic          sel_a_n,
    input logic          sel_b,
    input logic          sel_c_n,
    input logic          we_n,
    input logic          oe_n,
    input logic [DW-1:0] dout,
    input logic          dout_en
);

    logic sel;
    assign sel = !sel_a_n && sel_b && !sel_c_n;

    AST_WRITE_PHASE_OFF: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && sel && !we_n) |=> !dout_en); // R6

    AST_DESELECT_OFF: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !sel) |=> !dout_en); // R9

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && sel && we_n) |=> (dout_en == !oe_n)); // R2

    AST_OE_GATES: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dout_en); // R7

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cen_n && !oe_n) |=> ($stable(dout) && (oe_n || $stable(dout_en)))); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !dout_en); // R11

endmodule

bind ft_sync_ram ft_sync_ram_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cen_n   (cen_n),
    .sel_a_n (sel_a_n),
    .sel_b   (sel_b),
    .sel_c_n (sel_c_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/ft_sync_ram_test.sv
module ft_sync_ram_test;

    localparam int AW     = 5;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DW     = LANES * LANE_W;
    localparam int DEPTH  = 1 << AW;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cen_n = 1'b0;
    logic             sel_a_n = 1'b1;
    logic             sel_b = 1'b0;
    logic             sel_c_n = 1'b1;
    logic             we_n = 1'b1;
    logic [AW-1:0]    addr = '0;
    logic [LANES-1:0] bw_n = '1;
    logic             oe_n = 1'b0;
    logic [DW-1:0]    din = '0;
    logic [DW-1:0]    dout;
    logic             dout_en;

    always #4 clk = ~clk;

    ft_sync_ram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) uut (
        .clk(clk), .rst(rst), .cen_n(cen_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .we_n(we_n), .addr(addr), .bw_n(bw_n), .oe_n(oe_n),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    typedef struct {
        logic          en;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;

    // Requirement-level model of the visible state.
    logic [DW-1:0] m_mem [DEPTH];
    logic [1:0]    m_op = 2'd0;   // 0 idle, 1 read, 2 write
    logic [AW-1:0] m_addr = '0;

    task automatic drive(input logic c_n, input logic [2:0] sels, input logic w_n,
                         input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [LANES-1:0] bw, input logic oe, input string tag);
        exp_t e;
        @(negedge clk);
        cen_n = c_n; {sel_a_n, sel_b, sel_c_n} = sels; we_n = w_n;
        addr = a; din = d; bw_n = bw; oe_n = oe;
        if (!c_n) begin
            if (m_op == 2'd2)
                for (int i = 0; i < LANES; i++)
                    if (!bw[i]) m_mem[m_addr][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
            if (sels == 3'b010) m_op = w_n ? 2'd1 : 2'd2;
            else                m_op = 2'd0;
            m_addr = a;
        end
        e.en   = (m_op == 2'd1) && !oe;
        e.data = m_mem[m_addr];
        e.tag  = tag;
        q.push_back(e);
    endtask

    localparam logic [2:0] SEL = 3'b010;

    task automatic rd(input logic [AW-1:0] a, input string tag);
        drive(1'b0, SEL, 1'b1, a, '0, '1, 1'b0, tag);
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (dout_en !== e.en || (e.en && dout !== e.data)) begin
                errors++;
                $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
                         e.tag, dout_en, dout, e.en, e.data);
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (dout_en !== 1'b0) begin
            errors++;
            $display("FAIL R11: dout_en=%0b expected 0", dout_en);
        end
        @(negedge clk); rst = 1'b0;

        // Fill words 1..3, write data one edge after the address (R3, R4)
        drive(1'b0, SEL, 1'b0, 5'd1, '0, '1, 1'b0, "R3 wr addr 1");
        drive(1'b0, SEL, 1'b0, 5'd2, 36'h1_1111_1111, 4'b0000, 1'b0, "R3 wr addr 2");
        drive(1'b0, SEL, 1'b0, 5'd3, 36'h2_2222_2222, 4'b0000, 1'b0, "R4 wr addr 3");
        drive(1'b0, SEL, 1'b1, 5'd1, 36'h3_3333_3333, 4'b0000, 1'b0, "R4 rd after wr");
        rd(5'd2, "R2 read word 2");
        // partial write then immediate read of same word (R3, R5)
        drive(1'b0, SEL, 1'b0, 5'd3, '0, '1, 1'b0, "R6 write phase off");
        drive(1'b0, SEL, 1'b1, 5'd3, 36'hA_BCDE_F012, 4'b0101, 1'b0, "R5 merged read");
        // mask all ones leaves word unchanged (R3)
        drive(1'b0, SEL, 1'b0, 5'd2, '0, '1, 1'b1, "R6 write phase off with oe high");
        drive(1'b0, SEL, 1'b1, 5'd2, 36'hF_FFFF_FFFF, 4'b1111, 1'b0, "R3 mask ones no change");
        drive(1'b0, SEL, 1'b1, 5'd2, '0, '1, 1'b1, "R7 oe high read off");
        // R7 combinational gating within a cycle
        rd(5'd1, "R2 read word 1");
        @(posedge clk); #3;
        oe_n = 1'b1; #1;
        checks++;
        if (dout_en !== 1'b0) begin
            errors++;
            $display("FAIL R7: dout_en=%0b expected 0 right after oe_n rise", dout_en);
        end
        oe_n = 1'b0;
        // pending write held across suspended edges, completed on deselect (R8, R10, R1)
        drive(1'b0, SEL, 1'b0, 5'd1, '0, '1, 1'b0, "R6 write addr 1");
        drive(1'b1, SEL, 1'b1, 5'd7, 36'h0_DEAD_BEEF, 4'b0000, 1'b0, "R8 suspend holds");
        drive(1'b1, 3'b110, 1'b0, 5'd9, 36'h0_0BAD_0BAD, 4'b0000, 1'b0, "R8 R1 suspend ignores inputs");
        drive(1'b0, 3'b000, 1'b1, 5'd4, 36'h5_4444_5555, 4'b1100, 1'b0, "R9 R10 deselect off");
        rd(5'd1, "R10 pending write completed");
        // reads suspended: output holds while address changes (R8, R1)
        rd(5'd2, "R2 read word 2 again");
        drive(1'b1, SEL, 1'b1, 5'd3, '0, '1, 1'b0, "R8 R1 held read data");
        drive(1'b1, SEL, 1'b1, 5'd1, '0, '1, 1'b0, "R8 R1 held read data 2");
        // deselect patterns must not start writes (R9)
        drive(1'b0, 3'b110, 1'b0, 5'd2, '0, '1, 1'b0, "R9 sel_a_n high");
        drive(1'b0, 3'b000, 1'b0, 5'd2, 36'h7_7777_7777, 4'b0000, 1'b0, "R9 sel_b low");
        drive(1'b0, 3'b011, 1'b0, 5'd2, 36'h7_7777_7777, 4'b0000, 1'b0, "R9 sel_c_n high");
        drive(1'b0, SEL, 1'b1, 5'd2, 36'h7_7777_7777, 4'b0000, 1'b0, "R9 word 2 untouched");
        // long alternating run (R4)
        for (int k = 0; k < 16; k++) begin
            drive(1'b0, SEL, 1'b0, 5'(8 + k), 36'(k * 36'h1_0203_0405), 4'b0000, 1'b0, "R4 alt write");
            drive(1'b0, SEL, 1'b1, 5'(8 + ((k + 5) % 16)), 36'(36'h9_0000_0000 ^ (k * 36'h0_1357_9BDF)),
                  4'(k), 1'b0, "R4 alt read");
        end
        drive(1'b0, SEL, 1'b1, 5'd8, 36'h0_F0F0_F0F0, 4'b0000, 1'b0, "R4 final read");
        for (int k = 0; k < 16; k++) rd(5'(8 + k), "R4 readback");
        repeat (3) @(posedge clk);
        #4;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule